// File: doc/BRIEF.md
# CAN Receive Destuffer and Frame Checker

This block follows one CAN frame at a time from a stream of already sampled bus levels. One bit arrives on each sample-point strobe. A dominant bit marks the start of a frame once the bus has been seen idle. From that point the block removes stuff bits and walks through the header. Both the 11-bit and the 29-bit identifier layouts are supported. It then collects the data bytes and compares a CRC-15, computed over the destuffed bits, with the checksum carried in the frame.

Decoded header fields and data bytes appear on held output registers, each qualified by a one-cycle strobe. Three error strobes report a broken stuffing rule, a checksum mismatch, and a wrong level in a fixed-format bit. A frame that survives its seventh end-of-frame bit raises a success strobe. Bit timing, acknowledge driving, error counting and transmission belong to neighbouring blocks.

Top module: `can_rx_checker`

## Requirements
- R1: After reset the block reports nothing and accepts no start of frame until it has seen IDLE_BITS (default 11) consecutive recessive (1) bits; a dominant (0) bit before that restarts the count and is otherwise ignored.
- R2: Inside the stuffed region (start-of-frame through the CRC field), a bit of opposite level that follows five bits of equal level is discarded and does not enter any field or the checksum.
- R3: A sixth bit of equal level inside the stuffed region raises stuff_err for one cycle.
- R4: With the bit after the base identifier read as RTR and a dominant IDE bit, hdr_valid pulses after the fourth DLC bit with frame_ide=0, frame_id[10:0] holding the 11 identifier bits (first received bit in bit 10), frame_id[28:11]=0, frame_rtr and frame_dlc.
- R5: With a recessive IDE bit, 18 extension bits follow, then RTR, r1 and r0; hdr_valid reports frame_ide=1, frame_id={base, extension} and the RTR bit that follows the extension.
- R6: A data frame delivers min(DLC,8) bytes in order on byte_valid, with byte_idx counting from 0 and the first received bit as byte_data[7]; a frame with RTR=1 delivers no bytes whatever its DLC.
- R7: The checksum uses polynomial 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1), starts at zero at start-of-frame, and covers the destuffed bits through the end of the data field. A mismatch with the 15 received CRC bits (first bit in bit 14) raises crc_err when the CRC delimiter is taken.
- R8: When the last CRC bit completes a run of five, the stuff bit that follows is removed before the delimiter is read and the comparison is made.
- R9: A dominant CRC delimiter, ACK delimiter or end-of-frame bit 1 to 6 raises form_err; a dominant seventh end-of-frame bit raises no error.
- R10: frame_ok pulses after the seventh end-of-frame bit, and the very next dominant bit is taken as a new start of frame.
- R11: Any error strobe aborts the frame, and the block again requires IDLE_BITS consecutive recessive bits before a new start of frame.
- R12: A checksum mismatch on a frame whose CRC delimiter is also dominant raises crc_err and form_err in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Sample-point strobe, one per bus bit |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| hdr_valid | output | 1 | Header fields valid strobe |
| frame_id | output | 29 | Identifier |
| frame_ide | output | 1 | 1 for the 29-bit identifier layout |
| frame_rtr | output | 1 | Remote request bit |
| frame_dlc | output | 4 | Received length code |
| byte_valid | output | 1 | Data byte strobe |
| byte_data | output | 8 | Data byte |
| byte_idx | output | 3 | Position of the byte in the frame |
| frame_ok | output | 1 | Frame completed without error |
| stuff_err | output | 1 | Stuffing rule broken |
| crc_err | output | 1 | Checksum mismatch |
| form_err | output | 1 | Fixed-format bit dominant |

## Verification
The checksum comparison and the delimiter level check both act on the single CRC delimiter bit. A frame can therefore fail both in the same cycle. The bench provokes this by flipping one transmitted CRC bit and forcing that delimiter dominant. It expects one error item carrying both crc_err and form_err, with no stuff error and no success strobe. A second collision is between the trailing stuff bit and the delimiter read. Frames are searched until the last CRC bit closes a run of five, and the frame must still end in frame_ok.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int BASE_W    = 11;
  localparam int EXT_W     = 18;
  localparam int ID_W      = BASE_W + EXT_W;
  localparam int DLC_W     = 4;
  localparam int CRC_W     = 15;
  localparam int MAX_BYTES = 8;
  localparam int EOF_LEN   = 7;
  localparam int RUN_LEN   = 5;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  typedef enum logic [3:0] {
    ST_WAIT, ST_IDLE, ST_BASE, ST_B12, ST_IDE, ST_EXT, ST_RTR, ST_R1,
    ST_R0, ST_DLC, ST_DATA, ST_CRC, ST_CDEL, ST_ACK, ST_ADEL, ST_EOF
  } fld_e;
endpackage

// File: rtl/can_rx_destuff.sv
module can_rx_destuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic rx_bit,
  input  logic restart,
  input  logic track,
  output logic is_stuff,
  output logic stuff_hit
);
  localparam int CW = $clog2(RUN + 1);

  logic          last_q, last_d;
  logic [CW-1:0] run_q, run_d;
  logic          slot;

  assign slot = track && (run_q == CW'(RUN));

  always_comb begin
    is_stuff  = bit_valid && slot && (rx_bit != last_q);
    stuff_hit = bit_valid && slot && (rx_bit == last_q);
    last_d    = last_q;
    run_d     = run_q;
    if (bit_valid) begin
      if (restart) begin
        last_d = 1'b0;
        run_d  = CW'(1);
      end else if (track) begin
        if (slot || (rx_bit != last_q)) begin
          last_d = rx_bit;
          run_d  = CW'(1);
        end else begin
          run_d = run_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else begin
      last_q <= last_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/can_rx_crc15.sv
module can_rx_crc15 #(
  parameter int          W    = 15,
  parameter logic [W-1:0] POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  always_comb begin
    fb    = din ^ crc_q[W-1];
    crc_d = crc_q;
    if (clear) begin
      crc_d = '0;
    end else if (shift_en) begin
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/can_rx_field.sv
module can_rx_field
  import can_rx_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             rx_bit,
  input  logic             is_stuff,
  input  logic             stuff_hit,
  input  logic [CRC_W-1:0] crc_i,
  output logic             track,
  output logic             sof_take,
  output logic             crc_shift,
  output logic             hdr_valid,
  output logic [ID_W-1:0]  frame_id,
  output logic             frame_ide,
  output logic             frame_rtr,
  output logic [DLC_W-1:0] frame_dlc,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [2:0]       byte_idx,
  output logic             frame_ok,
  output logic             stuff_err,
  output logic             crc_err,
  output logic             form_err
);
  localparam int IW    = $clog2(IDLE_BITS + 1);
  localparam int CNT_W = (IW > 7) ? IW : 7;

  fld_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             ide_q, ide_d, rtr_q, rtr_d;
  logic [DLC_W-1:0] dlc_q, dlc_d;
  logic [3:0]       nby_q, nby_d;
  logic [7:0]       sh_q, sh_d, byte_q, byte_d;
  logic [2:0]       idx_q, idx_d;
  logic [CRC_W-1:0] rxcrc_q, rxcrc_d;
  logic             hdr_q, hdr_d, dv_q, dv_d, ok_q, ok_d;
  logic             ser_q, ser_d, cer_q, cer_d, fer_q, fer_d;
  logic             take;
  logic [3:0]       nb;

  assign take  = bit_valid && !is_stuff;
  assign track = (st_q == ST_BASE) || (st_q == ST_B12) || (st_q == ST_IDE) ||
                 (st_q == ST_EXT)  || (st_q == ST_RTR) || (st_q == ST_R1)  ||
                 (st_q == ST_R0)   || (st_q == ST_DLC) || (st_q == ST_DATA) ||
                 (st_q == ST_CRC)  || (st_q == ST_CDEL);

  always_comb begin
    sof_take  = take && (st_q == ST_IDLE) && !rx_bit;
    crc_shift = take && !stuff_hit &&
                ((st_q == ST_BASE) || (st_q == ST_B12) || (st_q == ST_IDE) ||
                 (st_q == ST_EXT)  || (st_q == ST_RTR) || (st_q == ST_R1)  ||
                 (st_q == ST_R0)   || (st_q == ST_DLC) || (st_q == ST_DATA));
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    id_d    = id_q;
    ide_d   = ide_q;
    rtr_d   = rtr_q;
    dlc_d   = dlc_q;
    nby_d   = nby_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    idx_d   = idx_q;
    rxcrc_d = rxcrc_q;
    hdr_d   = 1'b0;
    dv_d    = 1'b0;
    ok_d    = 1'b0;
    ser_d   = 1'b0;
    cer_d   = 1'b0;
    fer_d   = 1'b0;
    nb      = '0;
    if (bit_valid && stuff_hit) begin
      ser_d = 1'b1;
      st_d  = ST_WAIT;
      cnt_d = '0;
    end else if (take) begin
      unique case (st_q)
        ST_WAIT: begin
          if (!rx_bit) begin
            cnt_d = '0;
          end else if (cnt_q == CNT_W'(IDLE_BITS - 1)) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (!rx_bit) begin
            st_d  = ST_BASE;
            cnt_d = '0;
            id_d  = '0;
            ide_d = 1'b0;
            rtr_d = 1'b0;
            dlc_d = '0;
          end
        end
        ST_BASE: begin
          id_d = {id_q[ID_W-2:0], rx_bit};
          if (cnt_q == CNT_W'(BASE_W - 1)) begin
            st_d  = ST_B12;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_B12: begin
          rtr_d = rx_bit;
          st_d  = ST_IDE;
        end
        ST_IDE: begin
          ide_d = rx_bit;
          st_d  = rx_bit ? ST_EXT : ST_R0;
          cnt_d = '0;
        end
        ST_EXT: begin
          id_d = {id_q[ID_W-2:0], rx_bit};
          if (cnt_q == CNT_W'(EXT_W - 1)) begin
            st_d  = ST_RTR;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RTR: begin
          rtr_d = rx_bit;
          st_d  = ST_R1;
        end
        ST_R1: st_d = ST_R0;
        ST_R0: begin
          st_d  = ST_DLC;
          cnt_d = '0;
        end
        ST_DLC: begin
          dlc_d = {dlc_q[DLC_W-2:0], rx_bit};
          if (cnt_q == CNT_W'(DLC_W - 1)) begin
            hdr_d = 1'b1;
            if (rtr_q)                          nb = 4'd0;
            else if (dlc_d > 4'(MAX_BYTES))     nb = 4'(MAX_BYTES);
            else                                nb = 4'(dlc_d);
            nby_d = nb;
            st_d  = (nb == 4'd0) ? ST_CRC : ST_DATA;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          sh_d = {sh_q[6:0], rx_bit};
          if (cnt_q[2:0] == 3'd7) begin
            dv_d   = 1'b1;
            byte_d = sh_d;
            idx_d  = cnt_q[5:3];
          end
          if ((cnt_q + 1'b1) == CNT_W'({nby_q, 3'b000})) begin
            st_d  = ST_CRC;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_CRC: begin
          rxcrc_d = {rxcrc_q[CRC_W-2:0], rx_bit};
          if (cnt_q == CNT_W'(CRC_W - 1)) begin
            st_d  = ST_CDEL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_CDEL: begin
          cer_d = (rxcrc_q != crc_i);
          fer_d = !rx_bit;
          if (cer_d || fer_d) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
          end else begin
            st_d = ST_ACK;
          end
        end
        ST_ACK: st_d = ST_ADEL;
        ST_ADEL: begin
          cnt_d = '0;
          if (!rx_bit) begin
            fer_d = 1'b1;
            st_d  = ST_WAIT;
          end else begin
            st_d = ST_EOF;
          end
        end
        ST_EOF: begin
          if (cnt_q == CNT_W'(EOF_LEN - 1)) begin
            ok_d  = 1'b1;
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (!rx_bit) begin
            fer_d = 1'b1;
            st_d  = ST_WAIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_WAIT;
      cnt_q   <= '0;
      id_q    <= '0;
      ide_q   <= 1'b0;
      rtr_q   <= 1'b0;
      dlc_q   <= '0;
      nby_q   <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      idx_q   <= '0;
      rxcrc_q <= '0;
      hdr_q   <= 1'b0;
      dv_q    <= 1'b0;
      ok_q    <= 1'b0;
      ser_q   <= 1'b0;
      cer_q   <= 1'b0;
      fer_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      id_q    <= id_d;
      ide_q   <= ide_d;
      rtr_q   <= rtr_d;
      dlc_q   <= dlc_d;
      nby_q   <= nby_d;
      sh_q    <= sh_d;
      byte_q  <= byte_d;
      idx_q   <= idx_d;
      rxcrc_q <= rxcrc_d;
      hdr_q   <= hdr_d;
      dv_q    <= dv_d;
      ok_q    <= ok_d;
      ser_q   <= ser_d;
      cer_q   <= cer_d;
      fer_q   <= fer_d;
    end
  end

  assign hdr_valid  = hdr_q;
  assign frame_id   = id_q;
  assign frame_ide  = ide_q;
  assign frame_rtr  = rtr_q;
  assign frame_dlc  = dlc_q;
  assign byte_valid = dv_q;
  assign byte_data  = byte_q;
  assign byte_idx   = idx_q;
  assign frame_ok   = ok_q;
  assign stuff_err  = ser_q;
  assign crc_err    = cer_q;
  assign form_err   = fer_q;

  // R2: a discarded stuff bit leaves the field walk untouched
  a_r2_stuff_freezes_walk: assert property (@(posedge clk) disable iff (!rst_n)
    is_stuff |=> ($stable(st_q) && $stable(cnt_q)));

  // R7: the checksum must not move while the received CRC is collected
  a_r7_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && ((st_q == ST_CRC) || (st_q == ST_CDEL))) |=> $stable(crc_i));

  // R11: every error sends the block back to counting idle bits
  a_r11_abort_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_d || cer_d || fer_d) |=> ((st_q == ST_WAIT) && (cnt_q == '0)));

  // R6: no byte is delivered for a remote request
  a_r6_no_remote_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |-> !rtr_q);

  // R10: a completed frame leaves the block armed for a start bit
  a_r10_ok_then_armed: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> (st_q == ST_IDLE));

  // R9: form errors only come from the fixed-format tail bits
  a_r9_form_source: assert property (@(posedge clk) disable iff (!rst_n)
    fer_d |-> ((st_q == ST_CDEL) || (st_q == ST_ADEL) || (st_q == ST_EOF)));
endmodule

// File: rtl/can_rx_checker.sv
module can_rx_checker
  import can_rx_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_valid,
  input  logic        rx_bit,
  output logic        hdr_valid,
  output logic [28:0] frame_id,
  output logic        frame_ide,
  output logic        frame_rtr,
  output logic [3:0]  frame_dlc,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  output logic [2:0]  byte_idx,
  output logic        frame_ok,
  output logic        stuff_err,
  output logic        crc_err,
  output logic        form_err
);
  logic [1:0]       rst_sync;
  logic             rst_n_i;
  logic             is_stuff, stuff_hit, track, sof_take, crc_shift;
  logic [CRC_W-1:0] crc_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  can_rx_destuff #(.RUN(RUN_LEN)) u_destuff (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .bit_valid (bit_valid),
    .rx_bit    (rx_bit),
    .restart   (sof_take),
    .track     (track),
    .is_stuff  (is_stuff),
    .stuff_hit (stuff_hit)
  );

  can_rx_crc15 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clear    (sof_take),
    .shift_en (crc_shift),
    .din      (rx_bit),
    .crc      (crc_val)
  );

  can_rx_field #(.IDLE_BITS(IDLE_BITS)) u_field (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .bit_valid  (bit_valid),
    .rx_bit     (rx_bit),
    .is_stuff   (is_stuff),
    .stuff_hit  (stuff_hit),
    .crc_i      (crc_val),
    .track      (track),
    .sof_take   (sof_take),
    .crc_shift  (crc_shift),
    .hdr_valid  (hdr_valid),
    .frame_id   (frame_id),
    .frame_ide  (frame_ide),
    .frame_rtr  (frame_rtr),
    .frame_dlc  (frame_dlc),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_idx   (byte_idx),
    .frame_ok   (frame_ok),
    .stuff_err  (stuff_err),
    .crc_err    (crc_err),
    .form_err   (form_err)
  );
endmodule

// File: tb/can_rx_checker_tb.sv
module can_rx_checker_tb_top;
  localparam logic [3:0] K_HDR = 4'd1, K_DATA = 4'd2, K_OK = 4'd3, K_ERR = 4'd4;

  logic        clk = 1'b0;
  logic        rst_n, bit_valid, rx_bit;
  logic        hdr_valid, frame_ide, frame_rtr, byte_valid, frame_ok;
  logic        stuff_err, crc_err, form_err;
  logic [28:0] frame_id;
  logic [3:0]  frame_dlc;
  logic [7:0]  byte_data;
  logic [2:0]  byte_idx;

  int          checks = 0;
  int          fails  = 0;
  string       cur_tag = "R1";
  logic [39:0] exp_q[$];
  string       tag_q[$];

  logic        fb [0:255];
  int          fn, cdel_pos;
  bit          trail_stuff;
  logic [34:0] hdr_exp;
  int          nb_exp;

  always #10 clk = ~clk;

  can_rx_checker dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .hdr_valid(hdr_valid), .frame_id(frame_id), .frame_ide(frame_ide),
    .frame_rtr(frame_rtr), .frame_dlc(frame_dlc), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_idx(byte_idx), .frame_ok(frame_ok),
    .stuff_err(stuff_err), .crc_err(crc_err), .form_err(form_err)
  );

  function automatic logic [7:0] byte_of(input logic [7:0] d0, input int k);
    return d0 ^ 8'(k * 53);
  endfunction

  task automatic push(input logic [3:0] k, input logic [34:0] p, input string t);
    exp_q.push_back({k, 1'b0, p});
    tag_q.push_back(t);
  endtask

  // monitor: compare every reported item against the scoreboard queue
  always @(negedge clk) begin : monitor
    logic [39:0] obs, e;
    string       t;
    if (rst_n && (hdr_valid || byte_valid || frame_ok || stuff_err || crc_err || form_err)) begin
      if (stuff_err || crc_err || form_err) obs = {K_ERR, 33'd0, stuff_err, crc_err, form_err};
      else if (hdr_valid)  obs = {K_HDR, 1'b0, frame_ide, frame_rtr, frame_dlc, frame_id};
      else if (byte_valid) obs = {K_DATA, 25'd0, byte_idx, byte_data};
      else                 obs = {K_OK, 36'd0};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected item actual=%h expected=none", cur_tag, obs);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, obs, e);
        end
      end
    end
  end

  // build a frame into fb[]; crc_mask corrupts transmitted CRC bits
  task automatic build_frame(input bit ext, input bit rtr, input logic [28:0] id,
                             input logic [3:0] dlc, input logic [7:0] d0,
                             input logic [14:0] crc_mask, input int inter);
    logic        raw [0:159];
    int          rn = 0;
    logic [14:0] crc = '0;
    logic        nxt, last;
    int          run;
    nb_exp = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
    raw[rn++] = 1'b0;
    if (ext) begin
      for (int i = 28; i >= 18; i--) raw[rn++] = id[i];
      raw[rn++] = 1'b1;
      raw[rn++] = 1'b1;
      for (int i = 17; i >= 0; i--) raw[rn++] = id[i];
      raw[rn++] = rtr;
      raw[rn++] = 1'b0;
      raw[rn++] = 1'b0;
    end else begin
      for (int i = 10; i >= 0; i--) raw[rn++] = id[i];
      raw[rn++] = rtr;
      raw[rn++] = 1'b0;
      raw[rn++] = 1'b0;
    end
    for (int i = 3; i >= 0; i--) raw[rn++] = dlc[i];
    for (int k = 0; k < nb_exp; k++)
      for (int i = 7; i >= 0; i--) raw[rn++] = byte_of(d0, k)[i];
    for (int i = 0; i < rn; i++) begin
      nxt = raw[i] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (nxt) crc = crc ^ 15'h4599;
    end
    crc = crc ^ crc_mask;
    for (int i = 14; i >= 0; i--) raw[rn++] = crc[i];
    fn = 0; last = 1'b1; run = 0; trail_stuff = 0;
    for (int i = 0; i < rn; i++) begin
      fb[fn++] = raw[i];
      if (raw[i] == last) run++;
      else begin run = 1; last = raw[i]; end
      if (run == 5) begin
        fb[fn++] = ~last;
        last = ~last;
        run = 1;
        if (i == rn - 1) trail_stuff = 1;
      end
    end
    cdel_pos = fn;
    fb[fn++] = 1'b1;
    fb[fn++] = 1'b0;
    fb[fn++] = 1'b1;
    for (int i = 0; i < 7; i++) fb[fn++] = 1'b1;
    for (int i = 0; i < inter; i++) fb[fn++] = 1'b1;
    hdr_exp = {ext, rtr, dlc, ext ? id : {18'd0, id[10:0]}};
  endtask

  task automatic push_frame(input logic [7:0] d0, input bit with_ok,
                            input string htag, input string ok_tag);
    push(K_HDR, hdr_exp, htag);
    for (int k = 0; k < nb_exp; k++) push(K_DATA, 35'({3'(k), byte_of(d0, k)}), "R6");
    if (with_ok) push(K_OK, 35'd0, ok_tag);
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    rx_bit    = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    rx_bit    = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame_bits();
    for (int i = 0; i < fn; i++) drive_bit(fb[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL %s watchdog actual=running expected=finished", cur_tag);
    finish_run();
  end

  initial begin : stim
    bit found;
    rst_n = 1'b0; bit_valid = 1'b0; rx_bit = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (hdr_valid || byte_valid || frame_ok || stuff_err || crc_err || form_err) begin
      fails++;
      $display("FAIL R1 reset strobes actual=active expected=quiet");
    end

    // R1: early dominant bit ignored, then idle arms the block
    cur_tag = "R1";
    send_idle(3); drive_bit(1'b0); send_idle(12);

    // R4: standard data frame
    cur_tag = "R4";
    build_frame(0, 0, 29'h5A3, 4'd2, 8'hC4, 15'd0, 3);
    push_frame(8'hC4, 1, "R4", "R10"); send_frame_bits(); send_idle(12);

    // R2: heavy stuffing from all-zero content
    cur_tag = "R2";
    build_frame(0, 0, 29'h000, 4'd1, 8'h00, 15'd0, 3);
    push_frame(8'h00, 1, "R2", "R2"); send_frame_bits(); send_idle(12);
    build_frame(0, 0, 29'h7FF, 4'd8, 8'hFF, 15'd0, 3);
    push_frame(8'hFF, 1, "R2", "R2"); send_frame_bits(); send_idle(12);

    // R6: DLC above 8 and remote request
    cur_tag = "R6";
    build_frame(0, 0, 29'h2B1, 4'd12, 8'h5E, 15'd0, 3);
    push_frame(8'h5E, 1, "R6", "R6"); send_frame_bits(); send_idle(12);
    build_frame(0, 1, 29'h1C0, 4'd5, 8'h00, 15'd0, 3);
    push_frame(8'h00, 1, "R6", "R6"); send_frame_bits(); send_idle(12);

    // R5: extended layout, data and remote
    cur_tag = "R5";
    build_frame(1, 0, 29'h1ABCDE12, 4'd3, 8'h91, 15'd0, 3);
    push_frame(8'h91, 1, "R5", "R5"); send_frame_bits(); send_idle(12);
    build_frame(1, 1, 29'h0F0F0F0F, 4'd7, 8'h00, 15'd0, 3);
    push_frame(8'h00, 1, "R5", "R5"); send_frame_bits(); send_idle(12);

    // R10: back-to-back frames with no gap
    cur_tag = "R10";
    build_frame(0, 0, 29'h321, 4'd1, 8'hA7, 15'd0, 0);
    push_frame(8'hA7, 1, "R10", "R10"); send_frame_bits();
    build_frame(0, 0, 29'h654, 4'd2, 8'h3B, 15'd0, 3);
    push_frame(8'h3B, 1, "R10", "R10"); send_frame_bits(); send_idle(12);

    // R3 then R11: sixth equal bit, then early dominant ignored
    cur_tag = "R3";
    push(K_ERR, 35'(3'b100), "R3");
    for (int i = 0; i < 6; i++) drive_bit(1'b0);
    cur_tag = "R11";
    send_idle(4); drive_bit(1'b0); send_idle(12);
    build_frame(0, 0, 29'h0AB, 4'd1, 8'h66, 15'd0, 3);
    push_frame(8'h66, 1, "R11", "R11"); send_frame_bits(); send_idle(12);

    // R7: corrupted checksum
    cur_tag = "R7";
    build_frame(0, 0, 29'h4D2, 4'd2, 8'h19, 15'h0004, 3);
    push_frame(8'h19, 0, "R7", "R7"); push(K_ERR, 35'(3'b010), "R7");
    send_frame_bits(); send_idle(12);

    // R9: dominant CRC delimiter, ACK delimiter, EOF bit 4, EOF bit 7
    cur_tag = "R9";
    build_frame(0, 0, 29'h155, 4'd1, 8'h42, 15'd0, 3);
    fb[cdel_pos] = 1'b0;
    push_frame(8'h42, 0, "R9", "R9"); push(K_ERR, 35'(3'b001), "R9");
    send_frame_bits(); send_idle(12);
    build_frame(0, 0, 29'h155, 4'd1, 8'h42, 15'd0, 3);
    fb[cdel_pos + 2] = 1'b0;
    push_frame(8'h42, 0, "R9", "R9"); push(K_ERR, 35'(3'b001), "R9");
    send_frame_bits(); send_idle(12);
    build_frame(0, 0, 29'h155, 4'd1, 8'h42, 15'd0, 3);
    fb[cdel_pos + 6] = 1'b0;
    push_frame(8'h42, 0, "R9", "R9"); push(K_ERR, 35'(3'b001), "R9");
    send_frame_bits(); send_idle(12);
    build_frame(0, 0, 29'h155, 4'd1, 8'h42, 15'd0, 3);
    fb[cdel_pos + 9] = 1'b0;
    push_frame(8'h42, 1, "R9", "R9");
    send_frame_bits(); send_idle(12);

    // R8: stuff bit right after the last CRC bit
    cur_tag = "R8";
    found = 0;
    for (int v = 0; v < 256 && !found; v++) begin
      build_frame(0, 0, 29'h123, 4'd1, 8'(v), 15'd0, 3);
      if (trail_stuff) begin
        found = 1;
        push_frame(8'(v), 1, "R8", "R8");
      end
    end
    checks++;
    if (!found) begin
      fails++;
      $display("FAIL R8 search actual=none expected=frame with trailing stuff");
    end else begin
      send_frame_bits(); send_idle(12);
    end

    // R12: checksum mismatch and dominant delimiter together
    cur_tag = "R12";
    build_frame(0, 0, 29'h2E7, 4'd1, 8'hD0, 15'h0100, 3);
    fb[cdel_pos] = 1'b0;
    push_frame(8'hD0, 0, "R12", "R12"); push(K_ERR, 35'(3'b011), "R12");
    send_frame_bits(); send_idle(12);

    repeat (20) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s missing items actual=%0d expected=0", tag_q[0], exp_q.size());
    end
    finish_run();
  end
endmodule